// File: doc/BRIEF.md
# NAND Streaming FIFO Engine

This block moves a programmed number of bytes between a byte-wide NAND data port and a 64-byte host-side FIFO. The processor does not take part in each byte. Software picks a direction and a byte count, and optionally turns on DMA pacing, then pulses a start input. In the fetch direction the engine pulls bytes from the NAND port whenever the FIFO has room, and the host drains the FIFO in 32-bit words. In the post direction the host fills the FIFO with 16-bit halfwords, and the engine pushes bytes out to the NAND port whenever the FIFO holds data.

A single 32-bit status word reports two fields. Bits 13:0 hold the number of NAND-side bytes still to move; the transfer is finished when this field reaches zero. Bits 30:24 hold how many bytes the host may move right now: bytes held in the fetch direction, free bytes in the post direction. When DMA pacing is on, a request line is raised for each 64-byte frame. A start pulse that arrives while the engine is busy is refused and flagged. An abort input stops the engine and empties the FIFO.

The NAND side is a plain valid/ready byte handshake, so the timing generator behind it is not modelled.

Top module: `nand_stream_engine`

## Requirements
- R1: After reset the following all read zero: `eng_busy`, `eng_refused`, `nd_valid`, `dma_req` and `status_word`.
- R2: An accepted start loads `eng_count` into status bits 13:0 and raises `eng_busy` if the count is nonzero. Each NAND handshake (`nd_valid` and `nd_ready` both high at a clock edge) lowers that field by one. `eng_busy` falls on the edge that brings the field to zero.
- R3: Fetch direction (`eng_dir`=0). The first byte taken from `nd_rdata` appears on `hrd_data[7:0]` and the next three on the higher bytes, in order. A pop removes four bytes. A pop is ignored unless at least four bytes are held.
- R4: Fetch direction. `nd_valid` stays low while the FIFO holds 64 bytes, so fetching stalls with the remaining count unchanged.
- R5: Status bits 30:24 give the bytes held in the fetch direction and the free bytes (64 minus held) in the post direction. Bits 31 and 23:14 read zero.
- R6: Post direction (`eng_dir`=1). `hwr_data[7:0]` goes out on `nd_wdata` before `hwr_data[15:8]`. A push is accepted only when the engine is busy, at least two bytes are free, and the remaining count minus the bytes held is at least two. Any other push is ignored. `nd_valid` is high only while the FIFO holds data.
- R7: A start while busy leaves the transfer unchanged and pulses `eng_refused` for one cycle on the following edge.
- R8: An abort drops `eng_busy`, clears the remaining count, empties the FIFO and lowers `dma_req` on the next edge. An abort also overrides a start in the same cycle.
- R9: Fetch direction with DMA on. `dma_req` rises on the edge after the FIFO reaches 64 bytes, and falls on the edge where the host has popped 64 bytes since it rose.
- R10: Post direction with DMA on. `dma_req` rises on the edge after the engine is busy with an empty FIFO and at least 64 bytes remaining. It falls on the edge of the 32nd accepted push.
- R11: `dma_req` never rises when the transfer was started with `eng_dma_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_start | input | 1 | Start pulse |
| eng_dir | input | 1 | 0 fetch from NAND, 1 post to NAND |
| eng_dma_en | input | 1 | Enable per-frame DMA requests |
| eng_count | input | 14 | Byte count for the transfer |
| eng_abort | input | 1 | Stop the engine and empty the FIFO |
| eng_busy | output | 1 | Transfer in progress |
| eng_refused | output | 1 | One-cycle pulse: start refused while busy |
| status_word | output | 32 | Bits 30:24 host-available bytes, bits 13:0 remaining count |
| hrd_pop | input | 1 | Host pops one 32-bit word |
| hrd_data | output | 32 | Oldest four FIFO bytes, first byte in bits 7:0 |
| hwr_push | input | 1 | Host pushes one halfword |
| hwr_data | input | 16 | Halfword to push, low byte sent first |
| nd_valid | output | 1 | Engine offers a NAND byte transfer |
| nd_ready | input | 1 | NAND port accepts the transfer |
| nd_rdata | input | 8 | Byte from NAND in the fetch direction |
| nd_wdata | output | 8 | Byte to NAND in the post direction |
| dma_req | output | 1 | DMA frame request |

## Verification
Fetches are run three ways. A short 18-byte count shows word assembly and the rule that pops are ignored below four bytes. A 100-byte count with a stalled host shows the stall at a full FIFO with 36 bytes still pending. A DMA-paced 128-byte count shows the request edges frame by frame. Posts are run with the NAND side held off, so the free-byte field and the rejection of an excess push can be seen before draining and comparing byte order. A 64-byte DMA post shows the request falling on the 32nd halfword. A start issued mid-transfer, and an abort issued together with a start, separate the refusal path from the abort path.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  typedef enum logic {DIR_FETCH = 1'b0, DIR_POST = 1'b1} xfer_dir_e;
  localparam int STAT_LVL_W = 7;
  localparam int STAT_REM_W = 14;
  localparam int HOST_RD_BYTES = 4;
  localparam int HOST_WR_BYTES = 2;
endpackage

// File: rtl/nfe_byte_fifo.sv
// Byte FIFO: up to IN_MAX bytes enter and up to OUT_MAX bytes leave per cycle.
// DEPTH must be a power of two so that the pointers wrap naturally.
module nfe_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int IN_MAX = 2,
  parameter int OUT_MAX = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int INW = $clog2(IN_MAX + 1),
  localparam int OUTW = $clog2(OUT_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic [INW-1:0]         in_n,
  input  logic [8*IN_MAX-1:0]    in_data,
  input  logic [OUTW-1:0]        out_n,
  output logic [8*OUT_MAX-1:0]   head,
  output logic [CW-1:0]          level
);
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic [7:0]    mem_q [DEPTH];

  always_comb begin
    if (clear) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      wp_d  = wp_q + AW'(in_n);
      rp_d  = rp_q + AW'(out_n);
      lvl_d = lvl_q + CW'(in_n) - CW'(out_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      for (int i = 0; i < IN_MAX; i++) begin
        if (i < int'(in_n)) mem_q[wp_q + AW'(i)] <= in_data[8*i +: 8];
      end
    end
  end

  for (genvar g = 0; g < OUT_MAX; g++) begin : g_head
    assign head[8*g +: 8] = mem_q[rp_q + AW'(g)];
  end

  assign level = lvl_q;
endmodule

// File: rtl/nfe_ctrl.sv
// Transfer control: start/refuse/abort, remaining countdown, NAND handshake.
module nfe_ctrl
  import nfe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int FRAME = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic             dma_en,
  input  logic [CNT_W-1:0] count,
  input  logic             abort,
  input  logic [CW-1:0]    level,
  input  logic             nd_ready,
  output logic             busy,
  output logic [CNT_W-1:0] rem,
  output xfer_dir_e        dir_q,
  output logic             refused,
  output logic             fifo_clear,
  output logic             nd_valid,
  output logic             xfer,
  output logic             want_dma
);
  logic             busy_d, dma_q, dma_d, ref_d, start_ok;
  logic [CNT_W-1:0] rem_d;
  xfer_dir_e        dir_d;

  assign start_ok   = start && !busy && !abort;
  assign fifo_clear = abort || start_ok;
  assign nd_valid   = busy && ((dir_q == DIR_FETCH) ? (level < CW'(DEPTH)) : (level != '0));
  assign xfer       = nd_valid && nd_ready;
  assign want_dma   = dma_q && ((dir_q == DIR_FETCH) ? (level == CW'(DEPTH))
                                : (busy && level == '0 && rem >= CNT_W'(FRAME)));

  always_comb begin
    busy_d = busy;
    rem_d  = rem;
    dir_d  = dir_q;
    dma_d  = dma_q;
    ref_d  = start && busy && !abort;
    if (abort) begin
      busy_d = 1'b0;
      rem_d  = '0;
      dma_d  = 1'b0;
    end else if (start_ok) begin
      rem_d  = count;
      busy_d = (count != '0);
      dir_d  = xfer_dir_e'(dir);
      dma_d  = dma_en;
    end else if (xfer) begin
      rem_d  = rem - CNT_W'(1);
      busy_d = (rem != CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rem     <= '0;
      dir_q   <= DIR_FETCH;
      dma_q   <= 1'b0;
      refused <= 1'b0;
    end else begin
      busy    <= busy_d;
      rem     <= rem_d;
      dir_q   <= dir_d;
      dma_q   <= dma_d;
      refused <= ref_d;
    end
  end
endmodule

// File: rtl/nfe_dma_pacer.sv
// Raises a request when wanted and drops it once FRAME host bytes have moved.
module nfe_dma_pacer #(
  parameter int FRAME = 64,
  parameter int MOVE_W = 3,
  localparam int FCW = $clog2(FRAME) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              want,
  input  logic [MOVE_W-1:0] moved,
  output logic              req
);
  logic           req_d;
  logic [FCW-1:0] cnt_q, cnt_d, sum;

  assign sum = cnt_q + FCW'(moved);

  always_comb begin
    req_d = req;
    cnt_d = cnt_q;
    if (clear) begin
      req_d = 1'b0;
      cnt_d = '0;
    end else if (req) begin
      if (sum >= FCW'(FRAME)) begin
        req_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = sum;
      end
    end else if (want) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      cnt_q <= '0;
    end else begin
      req   <= req_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nand_stream_engine.sv
// Top: NAND streaming FIFO engine. DEPTH must be a power of two, at most 64 by the 7-bit status field.
module nand_stream_engine
  import nfe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int FRAME = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_start,
  input  logic             eng_dir,
  input  logic             eng_dma_en,
  input  logic [CNT_W-1:0] eng_count,
  input  logic             eng_abort,
  output logic             eng_busy,
  output logic             eng_refused,
  output logic [31:0]      status_word,
  input  logic             hrd_pop,
  output logic [31:0]      hrd_data,
  input  logic             hwr_push,
  input  logic [15:0]      hwr_data,
  output logic             nd_valid,
  input  logic             nd_ready,
  input  logic [7:0]       nd_rdata,
  output logic [7:0]       nd_wdata,
  output logic             dma_req
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int INW  = $clog2(HOST_WR_BYTES + 1);
  localparam int OUTW = $clog2(HOST_RD_BYTES + 1);
  localparam int MW   = 3;

  logic [CW-1:0]    level, free_b, lvl_field;
  logic [CNT_W-1:0] rem;
  logic [CNT_W:0]   pend;
  xfer_dir_e        dir_q;
  logic             fetch_mode, fifo_clear, xfer, want_dma, pop_ok, push_ok;
  logic [INW-1:0]   in_n;
  logic [OUTW-1:0]  out_n;
  logic [15:0]      in_data;
  logic [31:0]      head;
  logic [MW-1:0]    moved;

  nfe_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FRAME(FRAME)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .dir(eng_dir), .dma_en(eng_dma_en),
    .count(eng_count), .abort(eng_abort), .level(level), .nd_ready(nd_ready),
    .busy(eng_busy), .rem(rem), .dir_q(dir_q), .refused(eng_refused),
    .fifo_clear(fifo_clear), .nd_valid(nd_valid), .xfer(xfer), .want_dma(want_dma));

  assign fetch_mode = (dir_q == DIR_FETCH);
  assign free_b     = CW'(DEPTH) - level;
  assign pend       = {1'b0, rem} - (CNT_W+1)'(level);
  assign pop_ok     = hrd_pop && fetch_mode && (level >= CW'(HOST_RD_BYTES));
  assign push_ok    = hwr_push && !fetch_mode && eng_busy &&
                      (free_b >= CW'(HOST_WR_BYTES)) && (pend >= (CNT_W+1)'(HOST_WR_BYTES));

  always_comb begin
    if (fetch_mode) begin
      in_n    = xfer ? INW'(1) : '0;
      in_data = {8'h00, nd_rdata};
      out_n   = pop_ok ? OUTW'(HOST_RD_BYTES) : '0;
    end else begin
      in_n    = push_ok ? INW'(HOST_WR_BYTES) : '0;
      in_data = hwr_data;
      out_n   = xfer ? OUTW'(1) : '0;
    end
    if (pop_ok)       moved = MW'(HOST_RD_BYTES);
    else if (push_ok) moved = MW'(HOST_WR_BYTES);
    else              moved = '0;
  end

  nfe_byte_fifo #(.DEPTH(DEPTH), .IN_MAX(HOST_WR_BYTES), .OUT_MAX(HOST_RD_BYTES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .in_n(in_n), .in_data(in_data),
    .out_n(out_n), .head(head), .level(level));

  nfe_dma_pacer #(.FRAME(FRAME), .MOVE_W(MW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .want(want_dma), .moved(moved), .req(dma_req));

  assign lvl_field   = fetch_mode ? level : free_b;
  assign hrd_data    = head;
  assign nd_wdata    = head[7:0];
  assign status_word = {1'b0, STAT_LVL_W'(lvl_field), 10'b0, STAT_REM_W'(rem)};
endmodule

// File: rtl/nfe_checker.sv
module nfe_checker #(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic       eng_abort,
  input logic       eng_busy,
  input logic       eng_refused,
  input logic       nd_valid,
  input logic       nd_ready,
  input logic       dma_req,
  input logic [6:0] lvl_f,
  input logic [13:0] rem_f
);
  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_f <= 7'(DEPTH));

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_abort) |=> rem_f <= $past(rem_f));

  assert_handshake_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_valid && nd_ready && !eng_abort) |=> rem_f == $past(rem_f) - 14'd1);

  assert_valid_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nd_valid |-> eng_busy);

  // R4 and R6: no fetch into a full FIFO, no drain from an empty one (both show lvl_f == DEPTH)
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nd_valid |-> lvl_f != 7'(DEPTH));

  assert_refuse_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_busy && !eng_abort) |=> eng_refused);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> (!eng_busy && rem_f == 14'd0 && !dma_req));
endmodule

bind nand_stream_engine nfe_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_abort(eng_abort),
  .eng_busy(eng_busy), .eng_refused(eng_refused), .nd_valid(nd_valid),
  .nd_ready(nd_ready), .dma_req(dma_req), .lvl_f(status_word[30:24]),
  .rem_f(status_word[13:0]));

// File: tb/test_nand_stream_engine.sv
module test_nand_stream_engine;
  logic clk, rst_n;
  logic eng_start, eng_dir, eng_dma_en, eng_abort, eng_busy, eng_refused;
  logic [13:0] eng_count;
  logic [31:0] status_word, hrd_data;
  logic hrd_pop, hwr_push, nd_valid, nd_ready, dma_req;
  logic [15:0] hwr_data;
  logic [7:0] nd_rdata, nd_wdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [15:0] nd_idx;
  logic idx_clr;
  logic dma_mode_tb;
  logic stray_req;
  logic [7:0] wlog [256];

  nand_stream_engine i_nand_stream_engine (
    .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_dir(eng_dir),
    .eng_dma_en(eng_dma_en), .eng_count(eng_count), .eng_abort(eng_abort),
    .eng_busy(eng_busy), .eng_refused(eng_refused), .status_word(status_word),
    .hrd_pop(hrd_pop), .hrd_data(hrd_data), .hwr_push(hwr_push), .hwr_data(hwr_data),
    .nd_valid(nd_valid), .nd_ready(nd_ready), .nd_rdata(nd_rdata), .nd_wdata(nd_wdata),
    .dma_req(dma_req));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rd_byte(int i);
    return 8'(i * 13 + 5);
  endfunction
  function automatic logic [15:0] wr_half(int i);
    return 16'(i * 16'h0305 + 16'h0011);
  endfunction
  function automatic logic [31:0] rd_word(int i);
    return {rd_byte(i + 3), rd_byte(i + 2), rd_byte(i + 1), rd_byte(i)};
  endfunction

  // NAND port model
  assign nd_rdata = rd_byte(int'(nd_idx));
  always @(posedge clk) begin
    if (idx_clr) nd_idx <= '0;
    else if (nd_valid && nd_ready) begin
      wlog[nd_idx[7:0]] <= nd_wdata;
      nd_idx <= nd_idx + 16'd1;
    end
  end

  always @(negedge clk) if (rst_n && dma_req && !dma_mode_tb) stray_req <= 1'b1;

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic launch(logic dir, logic dma, int count);
    @(negedge clk);
    idx_clr = 1'b1;
    @(negedge clk);
    idx_clr = 1'b0;
    dma_mode_tb = dma;
    eng_dir = dir;
    eng_dma_en = dma;
    eng_count = 14'(count);
    eng_start = 1'b1;
    @(negedge clk);
    eng_start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(eng_busy), 0);
    chk("R1 status", status_word, 0);
    chk("R1 nd_valid/dma_req/refused", {29'd0, nd_valid, dma_req, eng_refused}, 0);
  endtask

  task automatic t_read_basic;
    nd_ready = 1'b1;
    launch(1'b0, 1'b0, 18);
    chk("R2 count loaded", {31'd0, eng_busy} << 16 | 32'(status_word[13:0]), 32'h0001_0012);
    repeat (22) @(negedge clk);
    chk("R2 done", {31'd0, eng_busy} << 16 | 32'(status_word[13:0]), 0);
    chk("R5 fetch level", status_word, 32'h1200_0000);
    for (int w = 0; w < 4; w++) begin
      chk("R3 word order", hrd_data, rd_word(4 * w));
      hrd_pop = 1'b1;
      @(negedge clk);
    end
    hrd_pop = 1'b1;
    @(negedge clk);
    hrd_pop = 1'b0;
    chk("R3 short pop ignored", 32'(status_word[30:24]), 2);
    nd_ready = 1'b0;
  endtask

  task automatic t_read_backpressure;
    int exp_idx = 0;
    int errs = 0;
    nd_ready = 1'b1;
    launch(1'b0, 1'b0, 100);
    repeat (80) @(negedge clk);
    chk("R4 stall level", 32'(status_word[30:24]), 64);
    chk("R4 stall remaining", 32'(status_word[13:0]), 36);
    chk("R4 stall valid", 32'(nd_valid), 0);
    for (int k = 0; k < 400 && exp_idx < 100; k++) begin
      if (status_word[30:24] >= 7'd4) begin
        if (hrd_data !== rd_word(exp_idx)) errs++;
        hrd_pop = 1'b1;
        exp_idx += 4;
      end else hrd_pop = 1'b0;
      @(negedge clk);
    end
    hrd_pop = 1'b0;
    chk("R3 stream data errors", 32'(errs), 0);
    chk("R4 all drained", {16'(exp_idx), 16'(status_word[13:0])}, {16'd100, 16'd0});
    nd_ready = 1'b0;
  endtask

  task automatic t_write;
    int errs = 0;
    nd_ready = 1'b0;
    launch(1'b1, 1'b0, 8);
    for (int h = 0; h < 4; h++) begin
      hwr_push = 1'b1;
      hwr_data = wr_half(h);
      @(negedge clk);
    end
    hwr_push = 1'b0;
    chk("R5 post free bytes", status_word, 32'h3800_0008);
    chk("R6 drain offered", 32'(nd_valid), 1);
    hwr_push = 1'b1;
    hwr_data = 16'hDEAD;
    @(negedge clk);
    hwr_push = 1'b0;
    chk("R6 excess push ignored", 32'(status_word[30:24]), 56);
    nd_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk("R2 post done", {31'd0, eng_busy} << 16 | 32'(status_word[13:0]), 0);
    for (int b = 0; b < 8; b++) begin
      logic [15:0] hw;
      hw = wr_half(b / 2);
      if (wlog[b] !== ((b % 2 == 0) ? hw[7:0] : hw[15:8])) errs++;
    end
    chk("R6 post byte order errors", 32'(errs), 0);
    hwr_push = 1'b1;
    hwr_data = 16'h1234;
    @(negedge clk);
    hwr_push = 1'b0;
    chk("R6 push while idle ignored", 32'(status_word[30:24]), 64);
    nd_ready = 1'b0;
  endtask

  task automatic t_refuse_abort;
    nd_ready = 1'b0;
    launch(1'b0, 1'b0, 40);
    eng_start = 1'b1;
    eng_count = 14'd5;
    @(negedge clk);
    eng_start = 1'b0;
    chk("R7 refused pulse", 32'(eng_refused), 1);
    chk("R7 count kept", 32'(status_word[13:0]), 40);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(eng_refused), 0);
    nd_ready = 1'b1;
    repeat (6) @(negedge clk);
    eng_abort = 1'b1;
    @(negedge clk);
    eng_abort = 1'b0;
    chk("R8 abort busy", 32'(eng_busy), 0);
    chk("R8 abort status", status_word, 0);
    eng_abort = 1'b1;
    eng_start = 1'b1;
    eng_count = 14'd9;
    @(negedge clk);
    eng_abort = 1'b0;
    eng_start = 1'b0;
    chk("R8 abort beats start", {31'd0, eng_busy} << 16 | 32'(status_word[13:0]), 0);
    nd_ready = 1'b0;
  endtask

  task automatic t_dma_read;
    int exp_idx = 0;
    int errs = 0;
    int k = 0;
    nd_ready = 1'b1;
    launch(1'b0, 1'b1, 128);
    while (status_word[30:24] != 7'd64 && k < 200) begin
      if (dma_req) errs++;
      k++;
      @(negedge clk);
    end
    chk("R9 no request before full", {16'(errs), 16'(dma_req)}, 0);
    @(negedge clk);
    chk("R9 request after full", 32'(dma_req), 1);
    for (int f = 0; f < 2; f++) begin
      k = 0;
      while (!dma_req && k < 200) begin
        k++;
        @(negedge clk);
      end
      for (int w = 0; w < 16; w++) begin
        if (hrd_data !== rd_word(exp_idx)) errs++;
        exp_idx += 4;
        hrd_pop = 1'b1;
        @(negedge clk);
      end
      hrd_pop = 1'b0;
      chk("R9 request drops after frame", 32'(dma_req), 0);
    end
    chk("R9 frame data errors", 32'(errs), 0);
    chk("R9 transfer complete", {31'd0, eng_busy} << 16 | 32'(status_word[13:0]), 0);
    nd_ready = 1'b0;
  endtask

  task automatic t_dma_write;
    int errs = 0;
    nd_ready = 1'b0;
    launch(1'b1, 1'b1, 64);
    chk("R10 request not yet", 32'(dma_req), 0);
    @(negedge clk);
    chk("R10 request raised", 32'(dma_req), 1);
    for (int h = 0; h < 32; h++) begin
      hwr_push = 1'b1;
      hwr_data = wr_half(h + 7);
      @(negedge clk);
    end
    hwr_push = 1'b0;
    chk("R10 request drops after 32 pushes", 32'(dma_req), 0);
    chk("R10 fifo full", 32'(status_word[30:24]), 0);
    nd_ready = 1'b1;
    repeat (70) @(negedge clk);
    for (int b = 0; b < 64; b++) begin
      logic [15:0] hw;
      hw = wr_half(b / 2 + 7);
      if (wlog[b] !== ((b % 2 == 0) ? hw[7:0] : hw[15:8])) errs++;
    end
    chk("R10 posted bytes errors", 32'(errs), 0);
    chk("R10 complete", {31'd0, eng_busy} << 16 | 32'(status_word[13:0]), 0);
    nd_ready = 1'b0;
    dma_mode_tb = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    eng_start = 1'b0; eng_dir = 1'b0; eng_dma_en = 1'b0; eng_abort = 1'b0;
    eng_count = '0; hrd_pop = 1'b0; hwr_push = 1'b0; hwr_data = '0; nd_ready = 1'b0;
    idx_clr = 1'b1; dma_mode_tb = 1'b0; stray_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idx_clr = 1'b0;
    t_reset();
    t_read_basic();
    t_read_backpressure();
    t_write();
    t_refuse_abort();
    chk("R11 no request without DMA", 32'(stray_req), 0);
    t_dma_read();
    t_dma_write();
    summary();
    $finish;
  end
endmodule